// File: doc/BRIEF.md
# Relocated Block Transfer Engine

This block moves a run of 60-bit words from one word-addressed memory to another. One side is a large backing store, the other a smaller main memory, and a request can go in either direction. A request carries the direction, a logical start word in each memory, a word count and a start-up latency in cycles. Each memory has its own relocation and bound pair. Every physical address is the relocation value plus the logical address, and the bound gives the size of the region that may be touched.

An accepted request freezes all of its fields and both region pairs. The block then checks both ranges. If either range does not fit, or the count is zero, the request completes at once with an error and touches no memory. Otherwise the block waits for the programmed latency and then streams one word per cycle. Each word is read from the source port and written one cycle later to the destination port. A one-cycle done pulse closes the transfer.

The controller is a single state machine with these states:
- **IDLE**: waits for a request.
- **CHECK**: evaluates the range and length test.
- **WAIT**: counts latency cycles.
- **STREAM**: issues one source read per cycle.
- **DRAIN**: writes the last word.
- **DONE**: pulses done.
- **REJECT**: pulses done and error together.

The transitions are:
- IDLE→CHECK on a request.
- CHECK→REJECT on a failed test.
- CHECK→STREAM when the latency is zero.
- CHECK→WAIT otherwise.
- WAIT→STREAM when the timer expires.
- STREAM→DRAIN on the last read.
- DRAIN→DONE.
- DONE→IDLE and REJECT→IDLE.

Top module: `blk_copy_engine`

## Requirements
- R1: With `req_dir`=0, word i is read from the backing store and written to main memory. With `req_dir`=1, word i is read from main memory and written to the backing store. Source logical word start+i lands at destination logical word start+i with all 60 bits unchanged.
- R2: Each physical address equals that memory's relocation value plus the logical address, modulo 2^width. Any start word is allowed in either memory.
- R3: A request whose start plus count exceeds the bound of either memory is rejected. It ends with `error` and `done` high together, two cycles after the acceptance cycle, and no memory access takes place. A range that ends exactly at the bound is accepted.
- R4: A request with a count of zero is rejected in the same way as R3 and makes no memory access.
- R5: If the request is accepted in cycle c with latency L, the first source read is issued in cycle c+2+L.
- R6: Source reads occupy N consecutive cycles, one word each. Each destination write follows its read by exactly one cycle.
- R7: `busy` rises in the cycle after acceptance and stays high through the done cycle. A request presented while `busy` is high is ignored.
- R8: `done` is high for exactly one cycle, in the cycle after the last destination write, which is cycle c+3+L+N.
- R9: The request fields and both relocation and bound pairs are sampled at acceptance. Changing them during a transfer has no effect on it.
- R10: While idle, no read or write enable is high, and the block never reads and writes the same memory in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_dir | input | 1 | 0: backing store to main, 1: main to backing store |
| req_bs_start | input | BS_AW | Logical start word in the backing store |
| req_mm_start | input | MM_AW | Logical start word in main memory |
| req_count | input | CNT_W | Number of words to move |
| req_latency | input | LAT_W | Start-up latency in cycles |
| bs_reloc | input | BS_AW | Backing store relocation value |
| bs_bound | input | BS_AW | Backing store region size in words |
| mm_reloc | input | MM_AW | Main memory relocation value |
| mm_bound | input | MM_AW | Main memory region size in words |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Rejection flag, high with done |
| bs_rd_en | output | 1 | Backing store read enable |
| bs_wr_en | output | 1 | Backing store write enable |
| bs_addr | output | BS_AW | Backing store physical word address |
| bs_wdata | output | 60 | Backing store write data |
| bs_rdata | input | 60 | Backing store read data, one cycle after the read |
| mm_rd_en | output | 1 | Main memory read enable |
| mm_wr_en | output | 1 | Main memory write enable |
| mm_addr | output | MM_AW | Main memory physical word address |
| mm_wdata | output | 60 | Main memory write data |
| mm_rdata | input | 60 | Main memory read data, one cycle after the read |

## Verification
The assertions check the following on every cycle:
- Every access falls inside the region frozen at acceptance.
- The enables stay quiet when idle.
- No memory is read and written together.
- Done lasts one cycle and error never appears without done.
- A rejected request made no access.
- Busy only drops after done.

Only the bench scenarios can show the rest:
- Data integrity and direction.
- Address wrap-around, exact-fit ranges and single-word transfers.
- Exact latency and done timing.
- The request strobe and region inputs being ignored mid-transfer.

// File: rtl/blk_copy_pkg.sv
package blk_copy_pkg;
    localparam int WORD_W = 60;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_WAIT,
        ST_STREAM,
        ST_DRAIN,
        ST_DONE,
        ST_REJECT
    } copy_state_e;
endpackage

// File: rtl/copy_limit_chk.sv
module copy_limit_chk #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic [AW-1:0] start,
    input  logic [CW-1:0] count,
    input  logic [AW-1:0] bound,
    output logic          fits
);
    localparam int SW = ((AW > CW) ? AW : CW) + 1;

    logic [SW-1:0] end_pos;

    always_comb begin
        end_pos = SW'(start) + SW'(count);
        fits    = (end_pos <= SW'(bound));
    end
endmodule

// File: rtl/copy_region.sv
module copy_region #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [AW-1:0] reloc_in,
    input  logic [AW-1:0] start_in,
    input  logic [AW-1:0] bound_in,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] idx,
    output logic          fits,
    output logic [AW-1:0] phys_addr
);
    logic [AW-1:0] start_q;
    logic [AW-1:0] bound_q;
    logic [AW-1:0] base_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
            bound_q <= '0;
            base_q  <= '0;
        end else if (capture) begin
            start_q <= start_in;
            bound_q <= bound_in;
            base_q  <= reloc_in + start_in;
        end
    end

    copy_limit_chk #(.AW(AW), .CW(CW)) u_lim (
        .start (start_q),
        .count (count),
        .bound (bound_q),
        .fits  (fits)
    );

    assign phys_addr = base_q + AW'(idx);
endmodule

// File: rtl/copy_lat_timer.sv
module copy_lat_timer #(
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [LW-1:0] load_val,
    output logic          expired
);
    logic [LW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/blk_copy_engine.sv
module blk_copy_engine
    import blk_copy_pkg::*;
#(
    parameter int BS_AW = 20,
    parameter int MM_AW = 15,
    parameter int CNT_W = 16,
    parameter int LAT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_dir,
    input  logic [BS_AW-1:0]  req_bs_start,
    input  logic [MM_AW-1:0]  req_mm_start,
    input  logic [CNT_W-1:0]  req_count,
    input  logic [LAT_W-1:0]  req_latency,
    input  logic [BS_AW-1:0]  bs_reloc,
    input  logic [BS_AW-1:0]  bs_bound,
    input  logic [MM_AW-1:0]  mm_reloc,
    input  logic [MM_AW-1:0]  mm_bound,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic              bs_rd_en,
    output logic              bs_wr_en,
    output logic [BS_AW-1:0]  bs_addr,
    output logic [WORD_W-1:0] bs_wdata,
    input  logic [WORD_W-1:0] bs_rdata,
    output logic              mm_rd_en,
    output logic              mm_wr_en,
    output logic [MM_AW-1:0]  mm_addr,
    output logic [WORD_W-1:0] mm_wdata,
    input  logic [WORD_W-1:0] mm_rdata
);
    copy_state_e state_q, state_d;

    logic             accept;
    logic             dir_q;
    logic [CNT_W-1:0] cnt_q;
    logic [LAT_W-1:0] lat_q;
    logic [CNT_W-1:0] rd_idx_q;
    logic [CNT_W-1:0] wr_idx_q;
    logic             wr_valid_q;
    logic             bs_fits, mm_fits;
    logic             lat_done;
    logic             last_rd;
    logic [CNT_W-1:0] bs_idx, mm_idx;

    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign last_rd = (rd_idx_q == CNT_W'(cnt_q - 1'b1));
    assign bs_idx  = dir_q ? wr_idx_q : rd_idx_q;
    assign mm_idx  = dir_q ? rd_idx_q : wr_idx_q;

    // Request snapshot: fields are frozen at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= 1'b0;
            cnt_q <= '0;
            lat_q <= '0;
        end else if (accept) begin
            dir_q <= req_dir;
            cnt_q <= req_count;
            lat_q <= req_latency;
        end
    end

    copy_region #(.AW(BS_AW), .CW(CNT_W)) u_bs_region (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (accept),
        .reloc_in  (bs_reloc),
        .start_in  (req_bs_start),
        .bound_in  (bs_bound),
        .count     (cnt_q),
        .idx       (bs_idx),
        .fits      (bs_fits),
        .phys_addr (bs_addr)
    );

    copy_region #(.AW(MM_AW), .CW(CNT_W)) u_mm_region (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (accept),
        .reloc_in  (mm_reloc),
        .start_in  (req_mm_start),
        .bound_in  (mm_bound),
        .count     (cnt_q),
        .idx       (mm_idx),
        .fits      (mm_fits),
        .phys_addr (mm_addr)
    );

    copy_lat_timer #(.LW(LAT_W)) u_lat (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state_q == ST_CHECK),
        .load_val (LAT_W'(lat_q - 1'b1)),
        .expired  (lat_done)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_CHECK;
            ST_CHECK: begin
                if (!(bs_fits && mm_fits) || (cnt_q == '0)) state_d = ST_REJECT;
                else if (lat_q == '0)                       state_d = ST_STREAM;
                else                                        state_d = ST_WAIT;
            end
            ST_WAIT:   if (lat_done) state_d = ST_STREAM;
            ST_STREAM: if (last_rd)  state_d = ST_DRAIN;
            ST_DRAIN:  state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            ST_REJECT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Word pipeline: read index and the one-cycle write stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_idx_q   <= '0;
            wr_idx_q   <= '0;
            wr_valid_q <= 1'b0;
        end else begin
            if (accept)                     rd_idx_q <= '0;
            else if (state_q == ST_STREAM)  rd_idx_q <= rd_idx_q + 1'b1;
            wr_idx_q   <= rd_idx_q;
            wr_valid_q <= (state_q == ST_STREAM);
        end
    end

    // Outputs
    always_comb begin
        busy     = (state_q != ST_IDLE);
        done     = (state_q == ST_DONE) || (state_q == ST_REJECT);
        error    = (state_q == ST_REJECT);
        bs_rd_en = (state_q == ST_STREAM) && !dir_q;
        mm_rd_en = (state_q == ST_STREAM) &&  dir_q;
        mm_wr_en = wr_valid_q && !dir_q;
        bs_wr_en = wr_valid_q &&  dir_q;
        mm_wdata = bs_rdata;
        bs_wdata = mm_rdata;
    end
endmodule

// File: rtl/blk_copy_checker.sv
module blk_copy_checker #(
    parameter int BS_AW = 20,
    parameter int MM_AW = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [BS_AW-1:0] bs_reloc,
    input logic [BS_AW-1:0] bs_bound,
    input logic [MM_AW-1:0] mm_reloc,
    input logic [MM_AW-1:0] mm_bound,
    input logic             busy,
    input logic             done,
    input logic             error,
    input logic             bs_rd_en,
    input logic             bs_wr_en,
    input logic [BS_AW-1:0] bs_addr,
    input logic             mm_rd_en,
    input logic             mm_wr_en,
    input logic [MM_AW-1:0] mm_addr
);
    logic             acc;
    logic             any_en;
    logic             touched_q;
    logic [BS_AW-1:0] s_bs_rel, s_bs_bnd;
    logic [MM_AW-1:0] s_mm_rel, s_mm_bnd;

    assign acc    = req_valid && !busy;
    assign any_en = bs_rd_en || bs_wr_en || mm_rd_en || mm_wr_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            touched_q <= 1'b0;
            s_bs_rel  <= '0;
            s_bs_bnd  <= '0;
            s_mm_rel  <= '0;
            s_mm_bnd  <= '0;
        end else if (acc) begin
            touched_q <= 1'b0;
            s_bs_rel  <= bs_reloc;
            s_bs_bnd  <= bs_bound;
            s_mm_rel  <= mm_reloc;
            s_mm_bnd  <= mm_bound;
        end else if (any_en) begin
            touched_q <= 1'b1;
        end
    end

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !any_en);

    assert_no_rw_same_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bs_rd_en && bs_wr_en) && !(mm_rd_en && mm_wr_en));

    assert_one_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(bs_rd_en && mm_rd_en));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_error_has_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done);

    // Covers R3 and R4: a rejected request has touched no memory
    assert_reject_no_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> !touched_q);

    assert_busy_until_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

    assert_bs_in_region_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bs_rd_en || bs_wr_en) |-> (BS_AW'(bs_addr - s_bs_rel) < s_bs_bnd));

    assert_mm_in_region_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_rd_en || mm_wr_en) |-> (MM_AW'(mm_addr - s_mm_rel) < s_mm_bnd));
endmodule

bind blk_copy_engine blk_copy_checker #(.BS_AW(BS_AW), .MM_AW(MM_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .bs_reloc  (bs_reloc),
    .bs_bound  (bs_bound),
    .mm_reloc  (mm_reloc),
    .mm_bound  (mm_bound),
    .busy      (busy),
    .done      (done),
    .error     (error),
    .bs_rd_en  (bs_rd_en),
    .bs_wr_en  (bs_wr_en),
    .bs_addr   (bs_addr),
    .mm_rd_en  (mm_rd_en),
    .mm_wr_en  (mm_wr_en),
    .mm_addr   (mm_addr)
);

// File: tb/blk_copy_engine_bench.sv
module blk_copy_engine_bench;
    localparam int BS_AW = 10;
    localparam int MM_AW = 8;
    localparam int CNT_W = 9;
    localparam int LAT_W = 4;
    localparam int BS_N  = 1 << BS_AW;
    localparam int MM_N  = 1 << MM_AW;

    typedef struct {
        bit          to_bs;
        int          addr;
        logic [59:0] data;
    } wr_item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic             req_valid = 1'b0;
    logic             req_dir = 1'b0;
    logic [BS_AW-1:0] req_bs_start = '0;
    logic [MM_AW-1:0] req_mm_start = '0;
    logic [CNT_W-1:0] req_count = '0;
    logic [LAT_W-1:0] req_latency = '0;
    logic [BS_AW-1:0] bs_reloc = '0, bs_bound = '0;
    logic [MM_AW-1:0] mm_reloc = '0, mm_bound = '0;
    logic             busy, done, error;
    logic             bs_rd_en, bs_wr_en, mm_rd_en, mm_wr_en;
    logic [BS_AW-1:0] bs_addr;
    logic [MM_AW-1:0] mm_addr;
    logic [59:0]      bs_wdata, mm_wdata;
    logic [59:0]      bs_rdata = '0, mm_rdata = '0;

    logic [59:0] bs_mem [BS_N];
    logic [59:0] mm_mem [MM_N];

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int wr_count = 0;
    int rd_count = 0;
    int first_rd_cyc = -1;
    bit rd_seen = 1'b0;
    wr_item_t exp_q[$];

    blk_copy_engine #(.BS_AW(BS_AW), .MM_AW(MM_AW), .CNT_W(CNT_W), .LAT_W(LAT_W))
    u_blk_copy_engine (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dir(req_dir),
        .req_bs_start(req_bs_start), .req_mm_start(req_mm_start),
        .req_count(req_count), .req_latency(req_latency),
        .bs_reloc(bs_reloc), .bs_bound(bs_bound),
        .mm_reloc(mm_reloc), .mm_bound(mm_bound),
        .busy(busy), .done(done), .error(error),
        .bs_rd_en(bs_rd_en), .bs_wr_en(bs_wr_en), .bs_addr(bs_addr),
        .bs_wdata(bs_wdata), .bs_rdata(bs_rdata),
        .mm_rd_en(mm_rd_en), .mm_wr_en(mm_wr_en), .mm_addr(mm_addr),
        .mm_wdata(mm_wdata), .mm_rdata(mm_rdata)
    );

    // Memory models: registered read, data one cycle after the address
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (bs_wr_en) bs_mem[bs_addr] <= bs_wdata;
        if (mm_wr_en) mm_mem[mm_addr] <= mm_wdata;
        bs_rdata <= bs_mem[bs_addr];
        mm_rdata <= mm_mem[mm_addr];
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on every destination write
    always @(negedge clk) begin
        if (rst_n) begin
            if (bs_rd_en || mm_rd_en) begin
                rd_count++;
                if (!rd_seen) begin
                    rd_seen = 1'b1;
                    first_rd_cyc = cyc;
                end
            end
            if (bs_wr_en || mm_wr_en) begin
                wr_count++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7", "unexpected write", wr_count, 0);
                end else begin
                    wr_item_t it;
                    it = exp_q.pop_front();
                    check(bs_wr_en == it.to_bs, "R1", "write direction", bs_wr_en, it.to_bs);
                    if (it.to_bs) begin
                        check(int'(bs_addr) == it.addr, "R2", "bs address", bs_addr, it.addr);
                        check(bs_wdata == it.data, "R1", "bs data", bs_wdata, it.data);
                    end else begin
                        check(int'(mm_addr) == it.addr, "R2", "mm address", mm_addr, it.addr);
                        check(mm_wdata == it.data, "R1", "mm data", mm_wdata, it.data);
                    end
                end
            end
        end
    end

    task automatic set_regions(input int br, input int bb, input int mr, input int mb);
        bs_reloc = BS_AW'(br);
        bs_bound = BS_AW'(bb);
        mm_reloc = MM_AW'(mr);
        mm_bound = MM_AW'(mb);
    endtask

    // Driver: issues one request and pushes its expected writes
    task automatic run_req(input bit dir, input int bs_s, input int mm_s, input int cnt,
                           input int lat, input bit exp_err, input bit disturb,
                           input string tag);
        int acc_cyc, done_cyc, wr0, rd0;
        logic [BS_AW-1:0] br0;
        logic [MM_AW-1:0] mr0;
        @(negedge clk);
        for (int i = 0; i < cnt && !exp_err; i++) begin
            wr_item_t it;
            int ba, ma;
            ba = (int'(bs_reloc) + bs_s + i) % BS_N;
            ma = (int'(mm_reloc) + mm_s + i) % MM_N;
            it.to_bs = dir;
            it.addr  = dir ? ba : ma;
            it.data  = dir ? mm_mem[ma] : bs_mem[ba];
            exp_q.push_back(it);
        end
        wr0 = wr_count;
        rd0 = rd_count;
        rd_seen = 1'b0;
        br0 = bs_reloc;
        mr0 = mm_reloc;
        req_valid    = 1'b1;
        req_dir      = dir;
        req_bs_start = BS_AW'(bs_s);
        req_mm_start = MM_AW'(mm_s);
        req_count    = CNT_W'(cnt);
        req_latency  = LAT_W'(lat);
        acc_cyc = cyc;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R7", {tag, " busy after accept"}, busy, 1);
        if (disturb) begin
            // R7 and R9: a competing request and new region values mid-transfer
            req_valid    = 1'b1;
            req_dir      = ~dir;
            req_count    = CNT_W'(2);
            req_latency  = '0;
            bs_reloc     = bs_reloc + 7;
            mm_reloc     = mm_reloc + 3;
            repeat (3) @(negedge clk);
            req_valid = 1'b0;
        end
        while (done !== 1'b1) @(negedge clk);
        done_cyc = cyc;
        check(done_cyc == acc_cyc + (exp_err ? 2 : 3 + lat + cnt), exp_err ? "R3" : "R8",
              {tag, " done cycle"}, done_cyc - acc_cyc, exp_err ? 2 : 3 + lat + cnt);
        check(error == exp_err, exp_err ? "R4" : "R3", {tag, " error flag"}, error, exp_err);
        check(busy == 1'b1, "R7", {tag, " busy in done cycle"}, busy, 1);
        bs_reloc = br0;
        mm_reloc = mr0;
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R8", {tag, " done pulse width"}, {done, busy}, 0);
        check(exp_q.size() == 0, "R6", {tag, " words outstanding"}, exp_q.size(), 0);
        if (exp_err) begin
            check(wr_count == wr0 && rd_count == rd0, "R3", {tag, " access on reject"},
                  (wr_count - wr0) + (rd_count - rd0), 0);
        end else begin
            check(first_rd_cyc == acc_cyc + 2 + lat, "R5", {tag, " first read cycle"},
                  first_rd_cyc - acc_cyc, 2 + lat);
            check(rd_count - rd0 == cnt && wr_count - wr0 == cnt, "R6", {tag, " word counts"},
                  rd_count - rd0, cnt);
        end
    endtask

    initial begin
        for (int i = 0; i < BS_N; i++) bs_mem[i] = {12'hB5A, 16'(i), 32'(i * 32'h9E3779B1)};
        for (int i = 0; i < MM_N; i++) mm_mem[i] = {12'h3C7, 16'(i), 32'(i * 32'h85EBCA6B)};
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && done == 1'b0 && error == 1'b0, "R7", "reset outputs",
              {busy, done, error}, 0);
        check(!(bs_rd_en || bs_wr_en || mm_rd_en || mm_wr_en), "R10", "reset enables",
              {bs_rd_en, bs_wr_en, mm_rd_en, mm_wr_en}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(busy == 1'b0, "R10", "idle after reset", busy, 0);

        set_regions(100, 200, 40, 100);
        run_req(1'b0, 5, 3, 7, 3, 1'b0, 1'b0, "R1 bs->mm");
        run_req(1'b1, 17, 61, 1, 0, 1'b0, 1'b0, "R1 single word mm->bs");
        run_req(1'b0, 184, 84, 16, 0, 1'b0, 1'b0, "R3 exact fit");
        run_req(1'b0, 0, 85, 16, 2, 1'b1, 1'b0, "R3 mm overrun");
        run_req(1'b1, 190, 0, 11, 1, 1'b1, 1'b0, "R3 bs overrun");
        run_req(1'b0, 4, 4, 0, 1, 1'b1, 1'b0, "R4 zero count");
        run_req(1'b1, 20, 10, 9, 5, 1'b0, 1'b1, "R9 frozen regions");
        set_regions(1020, 8, 250, 6);
        run_req(1'b0, 2, 2, 4, 1, 1'b0, 1'b0, "R2 wrap");
        run_req(1'b1, 3, 0, 5, 15, 1'b0, 1'b0, "R5 long latency");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R7 watchdog expired: actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule